// File: doc/BRIEF.md
# Full-Duplex Asynchronous Serial Port with Forced Parity

This block is a full-duplex asynchronous serial port. It sends words on one line and receives them on another. The two directions share only the configuration. A selector input picks one of several clock-enable sources. Every bit lasts eight ticks of the chosen source, and no other internal division is applied. The transmitter keeps that fixed divide with a free-running three-bit counter. The receiver uses the same eight ticks per bit as an oversampling grid.

The frame holds seven or eight data bits and one or two stop bits. Parity may be absent, or it may be a forced 0, a forced 1, odd or even. The transmitter and the receiver each give their own one-cycle completion pulse. The receiver keeps the last word it received with two flags: one for a bad stop bit and one for a parity mismatch. The timer or divider that makes the source ticks lies outside the block, and the block has no buffering.

Top module: `serial_uart`

## Requirements
- R1: After reset, `txd` is 1 and `txBusy`, `txDone` and `rxDone` are 0. Whenever `txBusy` is 0, `txd` is 1.
- R2: A transmitted frame is one start bit at 0, then the data bits least significant first (8 bits when `dataLen8`=1, the low 7 when 0), then the parity bit if enabled, then the stop bits at 1.
- R3: `parityMode` encoding: 0 = no parity bit, 1 = bit forced to 0, 2 = bit forced to 1, 3 = odd, 4 = even. Odd and even apply to the data bits plus the parity bit together.
- R4: `txDone` is a one-cycle pulse. It rises exactly (1 + data bits + parity bits + stop bits) x 8 source ticks after `txd` falls for the start bit. `twoStop`=1 adds one stop bit.
- R5: One bit lasts 8 ticks of `srcTick[srcSel]`. Ticks on the unselected sources have no effect.
- R6: A `txWrite` is accepted only when the transmitter is idle (`txBusy`=0). A write while busy is dropped, and this includes the edge on which `txDone` rises. An accepted write starts the start bit within one bit time.
- R7: After each received frame, `rxDone` pulses for one cycle and `rxData` holds the word. In 7-bit mode, `rxData[7]` is 0.
- R8: `rxFrameErr` is set on completion when the first stop bit reads 0, and is cleared otherwise. It changes only with `rxDone`.
- R9: `rxParityErr` is set on completion when the received parity bit differs from the one that R3 gives for the received data. With `parityMode`=0 it is always 0.
- R10: A low pulse on `rxd` that is gone by the middle of the start bit starts no reception.
- R11: Transmit and receive run at the same time without affecting each other. A frame looped from `txd` to `rxd` is received intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcTick | input | NUM_SRC | One clock-enable per selectable source |
| srcSel | input | clog2(NUM_SRC) | Index of the active source |
| dataLen8 | input | 1 | 1 = 8 data bits, 0 = 7 data bits |
| twoStop | input | 1 | 1 = two stop bits |
| parityMode | input | 3 | Parity mode, encoded as in R3 |
| txData | input | DATA_W | Word to transmit |
| txWrite | input | 1 | Write strobe for `txData` |
| txBusy | output | 1 | Transmitter has a word pending or a frame in progress |
| txDone | output | 1 | Transmit completion pulse |
| txd | output | 1 | Serial output line |
| rxd | input | 1 | Serial input line (asynchronous) |
| rxData | output | DATA_W | Last word received |
| rxDone | output | 1 | Receive completion pulse |
| rxFrameErr | output | 1 | First stop bit of the last frame was 0 |
| rxParityErr | output | 1 | Parity of the last frame mismatched |

## Verification
The transmitter's completion and a new write can land on the same clock edge. This is the edge that ends the last stop bit. The bench measures when the start bit falls and raises `txWrite` for exactly the edge on which the frame must end. It then expects `txDone` to be high, `txBusy` to be low and `txd` to stay at 1 for three bit times, which shows that the write was dropped. The write that follows on the next edge must then start a normal frame.

// File: rtl/serial_uart_pkg.sv
package serial_uart_pkg;

  typedef enum logic [2:0] {
    PAR_NONE = 3'd0,
    PAR_ZERO = 3'd1,
    PAR_ONE  = 3'd2,
    PAR_ODD  = 3'd3,
    PAR_EVEN = 3'd4
  } parMode_e;

  typedef enum logic [1:0] {
    LINE_MARK,
    LINE_SPACE,
    LINE_DATA,
    LINE_PAR
  } lineSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic     txLoad;
    logic     txShift;
    lineSel_e txLine;
    logic     rxShift;
    logic     rxParCap;
    logic     rxStopCap;
  } strobes_t;

endpackage

// File: rtl/serial_uart_ctrl.sv
module serial_uart_ctrl
  import serial_uart_pkg::*;
#(
  parameter int NUM_SRC    = 7,
  parameter int SEL_W      = 3,
  parameter int OVERSAMPLE = 8,
  parameter int DATA_W     = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcTick,
  input  logic [SEL_W-1:0]   srcSel,
  input  logic               dataLen8,
  input  logic               twoStop,
  input  parMode_e           parityMode,
  input  logic               txWrite,
  input  logic               rxd,
  output logic               rxBit,
  output strobes_t           stb,
  output logic               txBusy,
  output logic               txDone
);

  localparam int CNT_W = $clog2(OVERSAMPLE);
  localparam int IDX_W = $clog2(DATA_W + 3);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OVERSAMPLE - 1);
  localparam logic [CNT_W-1:0] CNT_MID  = CNT_W'(OVERSAMPLE / 2 - 1);

  typedef enum logic [2:0] {TX_IDLE, TX_START, TX_DATA, TX_PAR, TX_STOP} txState_e;
  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS, RX_HOLD} rxState_e;

  logic             tick;
  logic [IDX_W-1:0] nBits;
  logic             parOn;

  always_comb begin
    tick = 1'b0;
    for (int i = 0; i < NUM_SRC; i++)
      if (srcSel == SEL_W'(i)) tick = srcTick[i];
  end

  assign nBits = dataLen8 ? IDX_W'(DATA_W) : IDX_W'(DATA_W - 1);
  assign parOn = (parityMode != PAR_NONE);

  // transmitter
  txState_e         txState;
  logic [CNT_W-1:0] txDiv;
  logic [IDX_W-1:0] txBitCnt;
  logic             txStopCnt;
  logic             txPend;
  logic             bitTick;

  assign bitTick = tick && (txDiv == CNT_LAST);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txState   <= TX_IDLE;
      txDiv     <= '0;
      txBitCnt  <= '0;
      txStopCnt <= 1'b0;
      txPend    <= 1'b0;
      txDone    <= 1'b0;
    end else begin
      txDone <= 1'b0;
      if (tick) txDiv <= txDiv + 1'b1;
      if (stb.txLoad) txPend <= 1'b1;
      if (bitTick) begin
        unique case (txState)
          TX_IDLE: if (txPend) begin
            txState <= TX_START;
            txPend  <= 1'b0;
          end
          TX_START: begin
            txState  <= TX_DATA;
            txBitCnt <= '0;
          end
          TX_DATA: begin
            if (txBitCnt == nBits - 1'b1) begin
              txState   <= parOn ? TX_PAR : TX_STOP;
              txStopCnt <= 1'b0;
            end else begin
              txBitCnt <= txBitCnt + 1'b1;
            end
          end
          TX_PAR: begin
            txState   <= TX_STOP;
            txStopCnt <= 1'b0;
          end
          TX_STOP: begin
            if (twoStop && !txStopCnt) begin
              txStopCnt <= 1'b1;
            end else begin
              txState <= TX_IDLE;
              txDone  <= 1'b1;
            end
          end
          default: txState <= TX_IDLE;
        endcase
      end
    end
  end

  assign txBusy = (txState != TX_IDLE) || txPend;

  // receiver
  rxState_e         rxState;
  logic [1:0]       rxSync;
  logic [CNT_W-1:0] rxCnt;
  logic [IDX_W-1:0] rxIdx;
  logic             sampleNow;

  assign rxBit     = rxSync[1];
  assign sampleNow = tick && (rxState == RX_BITS) && (rxCnt == CNT_LAST);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxSync  <= 2'b11;
      rxState <= RX_IDLE;
      rxCnt   <= '0;
      rxIdx   <= '0;
    end else begin
      rxSync <= {rxSync[0], rxd};
      unique case (rxState)
        RX_IDLE: if (tick && !rxBit) begin
          rxState <= RX_START;
          rxCnt   <= '0;
        end
        RX_START: if (tick) begin
          if (rxCnt == CNT_MID) begin
            rxState <= rxBit ? RX_IDLE : RX_BITS;
            rxCnt   <= '0;
            rxIdx   <= '0;
          end else begin
            rxCnt <= rxCnt + 1'b1;
          end
        end
        RX_BITS: if (tick) begin
          rxCnt <= rxCnt + 1'b1;
          if (sampleNow) begin
            rxIdx <= rxIdx + 1'b1;
            if (stb.rxStopCap) rxState <= RX_HOLD;
          end
        end
        RX_HOLD: if (rxBit) rxState <= RX_IDLE;
        default: rxState <= RX_IDLE;
      endcase
    end
  end

  always_comb begin
    stb.txLoad    = txWrite && (txState == TX_IDLE) && !txPend;
    stb.txShift   = bitTick && (txState == TX_DATA);
    unique case (txState)
      TX_START: stb.txLine = LINE_SPACE;
      TX_DATA:  stb.txLine = LINE_DATA;
      TX_PAR:   stb.txLine = LINE_PAR;
      default:  stb.txLine = LINE_MARK;
    endcase
    stb.rxShift   = sampleNow && (rxIdx < nBits);
    stb.rxParCap  = sampleNow && (rxIdx == nBits) && parOn;
    stb.rxStopCap = sampleNow && !stb.rxShift && !stb.rxParCap;
  end

endmodule

// File: rtl/serial_uart_dp.sv
module serial_uart_dp
  import serial_uart_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          stb,
  input  logic [DATA_W-1:0] txData,
  input  logic              dataLen8,
  input  parMode_e          parityMode,
  input  logic              rxBit,
  output logic              txd,
  output logic [DATA_W-1:0] rxData,
  output logic              rxDone,
  output logic              rxFrameErr,
  output logic              rxParityErr
);

  logic [DATA_W-1:0] dataMask;
  logic [DATA_W-1:0] txShreg;
  logic              txParBit;
  logic [DATA_W-1:0] rxShreg;
  logic [DATA_W-1:0] rxWord;
  logic              rxParReg;

  function automatic logic parityOf(input logic [DATA_W-1:0] d, input parMode_e m);
    unique case (m)
      PAR_ONE:  return 1'b1;
      PAR_ODD:  return ~^d;
      PAR_EVEN: return ^d;
      default:  return 1'b0;
    endcase
  endfunction

  assign dataMask = dataLen8 ? {DATA_W{1'b1}} : {1'b0, {(DATA_W-1){1'b1}}};
  assign rxWord   = dataLen8 ? rxShreg : {1'b0, rxShreg[DATA_W-1:1]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txShreg     <= '0;
      txParBit    <= 1'b0;
      rxShreg     <= '0;
      rxParReg    <= 1'b0;
      rxData      <= '0;
      rxDone      <= 1'b0;
      rxFrameErr  <= 1'b0;
      rxParityErr <= 1'b0;
    end else begin
      if (stb.txLoad) begin
        txShreg  <= txData & dataMask;
        txParBit <= parityOf(txData & dataMask, parityMode);
      end else if (stb.txShift) begin
        txShreg <= txShreg >> 1;
      end
      if (stb.rxShift)  rxShreg  <= {rxBit, rxShreg[DATA_W-1:1]};
      if (stb.rxParCap) rxParReg <= rxBit;
      rxDone <= stb.rxStopCap;
      if (stb.rxStopCap) begin
        rxData      <= rxWord;
        rxFrameErr  <= !rxBit;
        rxParityErr <= (parityMode != PAR_NONE) && (rxParReg != parityOf(rxWord, parityMode));
      end
    end
  end

  always_comb begin
    unique case (stb.txLine)
      LINE_SPACE: txd = 1'b0;
      LINE_DATA:  txd = txShreg[0];
      LINE_PAR:   txd = txParBit;
      default:    txd = 1'b1;
    endcase
  end

endmodule

// File: rtl/serial_uart.sv
module serial_uart
  import serial_uart_pkg::*;
#(
  parameter int NUM_SRC    = 7,
  parameter int OVERSAMPLE = 8,
  parameter int DATA_W     = 8,
  parameter int SEL_W      = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcTick,
  input  logic [SEL_W-1:0]   srcSel,
  input  logic               dataLen8,
  input  logic               twoStop,
  input  logic [2:0]         parityMode,
  input  logic [DATA_W-1:0]  txData,
  input  logic               txWrite,
  output logic               txBusy,
  output logic               txDone,
  output logic               txd,
  input  logic               rxd,
  output logic [DATA_W-1:0]  rxData,
  output logic               rxDone,
  output logic               rxFrameErr,
  output logic               rxParityErr
);

  strobes_t stb;
  logic     rxBit;
  parMode_e parMode;

  assign parMode = parMode_e'(parityMode);

  serial_uart_ctrl #(
    .NUM_SRC(NUM_SRC), .SEL_W(SEL_W), .OVERSAMPLE(OVERSAMPLE), .DATA_W(DATA_W)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .srcTick(srcTick), .srcSel(srcSel),
    .dataLen8(dataLen8), .twoStop(twoStop), .parityMode(parMode),
    .txWrite(txWrite), .rxd(rxd), .rxBit(rxBit), .stb(stb),
    .txBusy(txBusy), .txDone(txDone)
  );

  serial_uart_dp #(.DATA_W(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .txData(txData),
    .dataLen8(dataLen8), .parityMode(parMode), .rxBit(rxBit),
    .txd(txd), .rxData(rxData), .rxDone(rxDone),
    .rxFrameErr(rxFrameErr), .rxParityErr(rxParityErr)
  );

endmodule

// File: rtl/serial_uart_checks.sv
module serial_uart_checks (
  input logic       clk,
  input logic       rstN,
  input logic       txBusy,
  input logic       txDone,
  input logic       txd,
  input logic       rxDone,
  input logic       rxFrameErr,
  input logic       rxParityErr,
  input logic [2:0] parityMode
);

  AST_IDLE_MARK: assert property (@(posedge clk) disable iff (!rstN)
    !txBusy |-> txd); // R1

  AST_TXDONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    txDone |=> !txDone); // R4

  AST_BUSY_ENDS_WITH_DONE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(txBusy) |-> txDone); // R4

  AST_DONE_LEAVES_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    txDone |-> !txBusy); // R6

  AST_RXDONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    rxDone |=> !rxDone); // R7

  AST_FRAME_FLAG_ON_DONE: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(rxFrameErr) |-> rxDone); // R8

  AST_NO_PARITY_CLEAN: assert property (@(posedge clk) disable iff (!rstN)
    (rxDone && parityMode == 3'd0) |-> !rxParityErr); // R9

endmodule

bind serial_uart serial_uart_checks checks_i (
  .clk(clk), .rstN(rstN), .txBusy(txBusy), .txDone(txDone), .txd(txd),
  .rxDone(rxDone), .rxFrameErr(rxFrameErr), .rxParityErr(rxParityErr),
  .parityMode(parityMode)
);

// File: tb/serial_uart_tb_top.sv
module serial_uart_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;
  localparam int NVEC       = 8;

  // {data, len8, twoStop, parityMode, badStop, badPar, pad}
  localparam logic [15:0] VECS [NVEC] = '{
    {8'hA5, 1'b1, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0},
    {8'h3C, 1'b1, 1'b1, 3'd3, 1'b0, 1'b0, 1'b0},
    {8'h5A, 1'b0, 1'b0, 3'd4, 1'b0, 1'b0, 1'b0},
    {8'hFF, 1'b0, 1'b1, 3'd1, 1'b0, 1'b0, 1'b0},
    {8'h01, 1'b1, 1'b0, 3'd2, 1'b0, 1'b0, 1'b0},
    {8'h80, 1'b1, 1'b0, 3'd4, 1'b0, 1'b1, 1'b0},
    {8'h55, 1'b1, 1'b1, 3'd0, 1'b1, 1'b0, 1'b0},
    {8'h6E, 1'b0, 1'b0, 3'd3, 1'b1, 1'b1, 1'b0}
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       phase = 1'b0;
  logic [6:0] srcTick;
  logic [2:0] srcSel = 3'd0;
  logic       dataLen8 = 1'b1, twoStop = 1'b0;
  logic [2:0] parityMode = 3'd0;
  logic [7:0] txData = 8'h00;
  logic       txWrite = 1'b0;
  logic       txBusy, txDone, txd, rxDone, rxFrameErr, rxParityErr;
  logic [7:0] rxData;
  logic       rxDrv = 1'b1, loopEn = 1'b0;
  logic       rxd;

  int checks = 0, fails = 0, cycle = 0, rxDoneCnt = 0;
  bit finished = 0;

  assign srcTick = {5'b0, phase, 1'b1};
  assign rxd = loopEn ? txd : rxDrv;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(negedge clk) phase = ~phase;
  always @(negedge clk) if (rxDone) rxDoneCnt++;

  serial_uart dut_i (
    .clk(clk), .rstN(rstN), .srcTick(srcTick), .srcSel(srcSel),
    .dataLen8(dataLen8), .twoStop(twoStop), .parityMode(parityMode),
    .txData(txData), .txWrite(txWrite), .txBusy(txBusy), .txDone(txDone),
    .txd(txd), .rxd(rxd), .rxData(rxData), .rxDone(rxDone),
    .rxFrameErr(rxFrameErr), .rxParityErr(rxParityErr)
  );

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  always @(posedge clk) begin
    cycle++;
    if (cycle > WATCHDOG && !finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual=%0d cycles expected<=%0d", cycle, WATCHDOG);
      report();
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic expPar(input logic [7:0] d, input logic [2:0] pm);
    case (pm)
      3'd2: return 1'b1;
      3'd3: return ~^d;
      3'd4: return ^d;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [15:0] buildFrame(input logic [7:0] d, input bit len8, input bit two,
                                             input logic [2:0] pm, input bit badPar,
                                             input bit badStop, output int nb);
    logic [15:0] f = '1;
    int i = 1;
    f[0] = 1'b0;
    for (int k = 0; k < (len8 ? 8 : 7); k++) begin
      f[i] = d[k];
      i++;
    end
    if (pm != 3'd0) begin
      f[i] = expPar(len8 ? d : (d & 8'h7F), pm) ^ badPar;
      i++;
    end
    f[i] = ~badStop;
    i++;
    if (two) i++;
    nb = i;
    return f;
  endfunction

  task automatic writeTx(input logic [7:0] d);
    @(negedge clk);
    txData = d;
    txWrite = 1'b1;
    @(negedge clk);
    txWrite = 1'b0;
  endtask

  task automatic txCapture(input int bp, input int nb, output logic [15:0] got, output int dur);
    int t0;
    got = '1;
    while (txd !== 1'b0) @(negedge clk);
    t0 = cycle;
    repeat (bp/2) @(negedge clk);
    got[0] = txd;
    for (int k = 1; k < nb; k++) begin
      repeat (bp) @(negedge clk);
      got[k] = txd;
    end
    while (txDone !== 1'b1) @(negedge clk);
    dur = cycle - t0;
  endtask

  task automatic rxSend(input int bp, input logic [15:0] f, input int nb);
    for (int k = 0; k < nb; k++) begin
      rxDrv = f[k];
      repeat (bp) @(negedge clk);
    end
    rxDrv = 1'b1;
    repeat (2*bp) @(negedge clk);
  endtask

  task automatic runTx(input int bp, input logic [7:0] d, input string tag);
    logic [15:0] expF, gotF;
    int nb, dur;
    expF = buildFrame(d, dataLen8, twoStop, parityMode, 1'b0, 1'b0, nb);
    writeTx(d);
    txCapture(bp, nb, gotF, dur);
    check(gotF == expF, {tag, " R2/R3 frame bits"}, gotF, expF);
    check(dur == nb*bp, {tag, " R4 done timing"}, dur, nb*bp);
  endtask

  initial begin
    logic [15:0] f;
    int nb, prev, t0;
    logic [7:0] d, expD;
    bit hiOk;

    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(txd === 1'b1 && txBusy === 1'b0 && txDone === 1'b0 && rxDone === 1'b0,
          "R1 reset state", {txd, txBusy, txDone, rxDone}, 4'b1000);

    // table walk: transmit then receive each vector
    for (int v = 0; v < NVEC; v++) begin
      d = VECS[v][15:8];
      dataLen8 = VECS[v][7];
      twoStop = VECS[v][6];
      parityMode = VECS[v][5:3];
      runTx(8, d, "vec");
      expD = dataLen8 ? d : (d & 8'h7F);
      f = buildFrame(d, dataLen8, twoStop, parityMode, VECS[v][1], VECS[v][2], nb);
      prev = rxDoneCnt;
      rxSend(8, f, nb);
      check(rxDoneCnt == prev + 1, "R7 one rxDone per frame", rxDoneCnt - prev, 1);
      check(rxData == expD, "R7 rxData", rxData, expD);
      check(rxFrameErr == VECS[v][2], "R8 framing flag", rxFrameErr, VECS[v][2]);
      check(rxParityErr == VECS[v][1], "R9 parity flag", rxParityErr, VECS[v][1]);
    end

    // R5: second source ticks every other cycle, so a bit is 16 cycles
    srcSel = 3'd1; dataLen8 = 1'b1; twoStop = 1'b0; parityMode = 3'd4;
    runTx(16, 8'hC3, "R5 slow source");
    f = buildFrame(8'hC3, 1'b1, 1'b0, 3'd4, 1'b0, 1'b0, nb);
    prev = rxDoneCnt;
    rxSend(16, f, nb);
    check(rxDoneCnt == prev + 1 && rxData == 8'hC3 && !rxParityErr,
          "R5 rx on slow source", rxData, 8'hC3);
    srcSel = 3'd0;

    // R6: write while busy is dropped
    parityMode = 3'd0;
    begin
      logic [15:0] expF, gotF;
      int dur;
      expF = buildFrame(8'h11, 1'b1, 1'b0, 3'd0, 1'b0, 1'b0, nb);
      writeTx(8'h11);
      fork
        txCapture(8, nb, gotF, dur);
        begin
          repeat (20) @(negedge clk);
          txData = 8'hEE; txWrite = 1'b1;
          @(negedge clk);
          txWrite = 1'b0;
        end
      join
      check(gotF == expF, "R6 busy write dropped", gotF, expF);
    end
    hiOk = 1;
    repeat (24) begin
      @(negedge clk);
      if (txd !== 1'b1 || txBusy !== 1'b0) hiOk = 0;
    end
    check(hiOk, "R6 no extra frame after busy write", hiOk, 1);

    // R6: write landing on the txDone edge is dropped
    f = buildFrame(8'h42, 1'b1, 1'b0, 3'd0, 1'b0, 1'b0, nb);
    writeTx(8'h42);
    while (txd !== 1'b0) @(negedge clk);
    t0 = cycle;
    while (cycle != t0 + nb*8 - 1) @(negedge clk);
    txData = 8'h99; txWrite = 1'b1;
    @(negedge clk);
    txWrite = 1'b0;
    check(txDone === 1'b1, "R6 txDone on the write edge", txDone, 1);
    check(txBusy === 1'b0, "R6 done-edge write not taken", txBusy, 0);
    hiOk = 1;
    repeat (24) begin
      @(negedge clk);
      if (txd !== 1'b1 || txBusy !== 1'b0) hiOk = 0;
    end
    check(hiOk, "R6 line idle after done-edge write", hiOk, 1);
    // next write is accepted normally
    runTx(8, 8'h99, "R6 follow-up");

    // R10: short low glitch is not a start bit
    prev = rxDoneCnt;
    rxDrv = 1'b0;
    repeat (2) @(negedge clk);
    rxDrv = 1'b1;
    repeat (40) @(negedge clk);
    check(rxDoneCnt == prev, "R10 glitch ignored", rxDoneCnt - prev, 0);
    f = buildFrame(8'h7E, 1'b1, 1'b0, 3'd0, 1'b0, 1'b0, nb);
    rxSend(8, f, nb);
    check(rxDoneCnt == prev + 1 && rxData == 8'h7E, "R10 receiver ready after glitch", rxData, 8'h7E);

    // R11: loopback, both directions active together
    loopEn = 1'b1; twoStop = 1'b1; parityMode = 3'd4;
    prev = rxDoneCnt;
    runTx(8, 8'h96, "R11 loopback tx");
    repeat (16) @(negedge clk);
    check(rxDoneCnt == prev + 1 && rxData == 8'h96 && !rxFrameErr && !rxParityErr,
          "R11 loopback rx", rxData, 8'h96);
    loopEn = 1'b0;

    finished = 1;
    report();
    $finish;
  end

endmodule